// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block decides which operating mode a CAN protocol controller is in. There are four modes: reset/initialization, operation, sleep and interface sleep. The host drives level control bits for a reset request, a sleep request, an interface-sleep request and loopback. The block moves between the modes only along the permitted paths. Sleep can only be reached from reset mode, and interface sleep only from sleep. On the way back the block steps through the same modes in reverse and skips none of them.

After the block enters operation mode, it watches the bus samples that the bit-level engine delivers once per bit time. The node becomes bus-active only after a run of consecutive recessive samples, 11 by default. While bus-active, the block follows the idle, receive and transmit sub-modes from the start-of-frame, transmit-start, arbitration-lost and frame-finished events. It reports the sub-mode on two flags.

A bus-off indication from the error logic forces the block back to reset mode. The block drives two clock enables, one for the protocol core and one for the CPU interface, and lowers each one in the same cycle as the matching low-power mode begins.

Top module: `can_mode_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block is in reset mode: `mode_reset`=1, `mode_sleep`=`mode_ifsleep`=0, `trm_state`=`rec_state`=`loop_rx`=`bus_active`=0, and both clock enables are 1.
- R2: In reset mode, with `reset_req`=0 and `sleep_req`=0, the block enters operation mode at the next clock edge. In operation mode all three mode flags read 0.
- R3: In operation mode, a cycle with `bit_tick`=1 and `bus_recessive`=1 counts one recessive bit, and a tick with `bus_recessive`=0 clears the count. `bus_active` rises one cycle after the 11th consecutive recessive tick (IDLE_BITS=11) and not before.
- R4: Sleep mode is entered only from reset mode, when `sleep_req`=1 and `reset_req`=0. A sleep request made during operation mode leaves the mode and `bus_active` unchanged.
- R5: `core_clk_en` is 0 exactly while the block is in sleep or interface sleep mode, and it changes in the same cycle as the mode flag.
- R6: Interface sleep mode is entered only from sleep mode, when `ifsleep_req`=1. `cpu_if_clk_en` is 0 exactly in interface sleep. A request made in reset mode is ignored.
- R7: The sub-mode is encoded on {`trm_state`,`rec_state`}: 00 idle, 10 transmit, 01 receive. From idle, `tx_start` leads to transmit (it wins over `sof_det`) and `sof_det` leads to receive. `frame_done` returns the block to idle. While `bus_active`=0 these events are ignored and the flags stay at 00.
- R8: `arb_lost` in the transmit sub-mode moves the flags directly to receive (01) at the next edge, and it takes priority over `frame_done`.
- R9: `loop_rx` is 1 while transmitting if `loopback` was 1 when transmission began or continued. Otherwise it is 0.
- R10: In operation mode, `reset_req`=1 or `bus_off`=1 returns the block to reset mode at the next edge. In that same cycle `bus_active`, the recessive count and both sub-mode flags are cleared.
- R11: In interface sleep, clearing `ifsleep_req` returns the block to sleep mode. In sleep, clearing `sleep_req` returns it to reset mode. Each step takes one edge, so clearing both requests together still passes through sleep mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Host request for reset/initialization mode |
| sleep_req | input | 1 | Host request for sleep mode |
| ifsleep_req | input | 1 | Host request for interface sleep mode |
| loopback | input | 1 | Self-reception of transmitted frames enabled |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| bus_recessive | input | 1 | Sampled bus level, 1 = recessive |
| sof_det | input | 1 | Start of frame detected |
| tx_start | input | 1 | Transmission starts |
| arb_lost | input | 1 | Arbitration lost |
| frame_done | input | 1 | Current frame finished |
| bus_off | input | 1 | Error logic reports bus-off |
| mode_reset | output | 1 | In reset/initialization mode |
| mode_sleep | output | 1 | In sleep mode |
| mode_ifsleep | output | 1 | In interface sleep mode |
| bus_active | output | 1 | Node takes part in bus traffic; fault confinement released |
| trm_state | output | 1 | Sub-mode flag: transmitting |
| rec_state | output | 1 | Sub-mode flag: receiving |
| loop_rx | output | 1 | Own frame is being received in loopback |
| core_clk_en | output | 1 | Clock enable for the protocol core |
| cpu_if_clk_en | output | 1 | Clock enable for the CPU interface |

## Verification
The assertions check on every cycle the following properties:
- that the two sub-mode flags are never both set;
- that sleep is entered only from reset mode, and interface sleep only from sleep;
- that the interface clock is never off while the core clock is on;
- that bus-active rises only on a recessive tick and never outside operation mode;
- that arbitration loss leads to receive;
- that bus-off forces reset mode.

Only the bench's scenarios can show the exact length of the recessive run. It sweeps runs from 1 to 10 bits that are broken by a dominant bit, and then a full run of 11. The scenarios also cover requests that are ignored in the wrong mode and the step-by-step wake-up order.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [1:0] {
        MODE_RESET   = 2'd0,
        MODE_OPER    = 2'd1,
        MODE_SLEEP   = 2'd2,
        MODE_IFSLEEP = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SUB_IDLE = 2'd0,
        SUB_TX   = 2'd1,
        SUB_RX   = 2'd2
    } sub_e;

endpackage

// File: rtl/can_idle_detect.sv
module can_idle_detect #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bit_tick,
    input  logic bus_recessive,
    output logic active
);
    localparam int CNT_W = $clog2(IDLE_BITS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             act;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.act = 1'b0;
        end else if (!st_q.act && bit_tick) begin
            if (!bus_recessive) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == CNT_W'(IDLE_BITS - 1)) begin
                st_d.cnt = '0;
                st_d.act = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.act;

endmodule

// File: rtl/can_submode_trk.sv
module can_submode_trk
    import can_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic loopback,
    input  logic sof_det,
    input  logic tx_start,
    input  logic arb_lost,
    input  logic frame_done,
    output logic trm_state,
    output logic rec_state,
    output logic loop_rx
);
    typedef struct packed {
        sub_e sub;
        logic lrx;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.sub = SUB_IDLE;
        end else begin
            unique case (st_q.sub)
                SUB_IDLE: begin
                    if (tx_start)     st_d.sub = SUB_TX;
                    else if (sof_det) st_d.sub = SUB_RX;
                end
                SUB_TX: begin
                    if (arb_lost)        st_d.sub = SUB_RX;
                    else if (frame_done) st_d.sub = SUB_IDLE;
                end
                SUB_RX: begin
                    if (frame_done) st_d.sub = SUB_IDLE;
                end
                default: st_d.sub = SUB_IDLE;
            endcase
        end
        st_d.lrx = (st_d.sub == SUB_TX) && loopback;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sub: SUB_IDLE, lrx: 1'b0};
        else        st_q <= st_d;
    end

    assign trm_state = (st_q.sub == SUB_TX);
    assign rec_state = (st_q.sub == SUB_RX);
    assign loop_rx   = st_q.lrx;

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reset_req,
    input  logic sleep_req,
    input  logic ifsleep_req,
    input  logic loopback,
    input  logic bit_tick,
    input  logic bus_recessive,
    input  logic sof_det,
    input  logic tx_start,
    input  logic arb_lost,
    input  logic frame_done,
    input  logic bus_off,
    output logic mode_reset,
    output logic mode_sleep,
    output logic mode_ifsleep,
    output logic bus_active,
    output logic trm_state,
    output logic rec_state,
    output logic loop_rx,
    output logic core_clk_en,
    output logic cpu_if_clk_en
);
    typedef struct packed {
        mode_e mode;
    } seq_t;

    seq_t st_d, st_q;
    logic oper_next;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            MODE_RESET: begin
                if (!reset_req) st_d.mode = sleep_req ? MODE_SLEEP : MODE_OPER;
            end
            MODE_OPER: begin
                if (reset_req || bus_off) st_d.mode = MODE_RESET;
            end
            MODE_SLEEP: begin
                if (!sleep_req)       st_d.mode = MODE_RESET;
                else if (ifsleep_req) st_d.mode = MODE_IFSLEEP;
            end
            MODE_IFSLEEP: begin
                if (!ifsleep_req) st_d.mode = MODE_SLEEP;
            end
            default: st_d.mode = MODE_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_RESET};
        else        st_q <= st_d;
    end

    assign oper_next = (st_d.mode == MODE_OPER);

    can_idle_detect #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (oper_next),
        .bit_tick      (bit_tick),
        .bus_recessive (bus_recessive),
        .active        (bus_active)
    );

    can_submode_trk u_sub (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (oper_next && bus_active),
        .loopback   (loopback),
        .sof_det    (sof_det),
        .tx_start   (tx_start),
        .arb_lost   (arb_lost),
        .frame_done (frame_done),
        .trm_state  (trm_state),
        .rec_state  (rec_state),
        .loop_rx    (loop_rx)
    );

    assign mode_reset    = (st_q.mode == MODE_RESET);
    assign mode_sleep    = (st_q.mode == MODE_SLEEP);
    assign mode_ifsleep  = (st_q.mode == MODE_IFSLEEP);
    assign core_clk_en   = !(mode_sleep || mode_ifsleep);
    assign cpu_if_clk_en = !mode_ifsleep;

endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic reset_req,
    input logic bit_tick,
    input logic bus_recessive,
    input logic arb_lost,
    input logic bus_off,
    input logic mode_reset,
    input logic mode_sleep,
    input logic mode_ifsleep,
    input logic bus_active,
    input logic trm_state,
    input logic rec_state,
    input logic core_clk_en,
    input logic cpu_if_clk_en
);
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(trm_state && rec_state));

    a_r4_sleep_from_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sleep && !$past(mode_sleep) && !$past(mode_ifsleep)) |-> $past(mode_reset));

    a_r6_ifsleep_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ifsleep && !$past(mode_ifsleep)) |-> $past(mode_sleep));

    a_r6_clock_order: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_if_clk_en |-> !core_clk_en);

    a_r3_active_only_oper: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active |-> (!mode_reset && !mode_sleep && !mode_ifsleep));

    a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_active) |-> ($past(bit_tick) && $past(bus_recessive)));

    a_r8_arb_to_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (trm_state && arb_lost && !reset_req && !bus_off) |=> (rec_state && !trm_state));

    a_r10_bus_off: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !mode_reset && !mode_sleep && !mode_ifsleep)
        |=> (mode_reset && !bus_active && !trm_state && !rec_state));
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reset_req     (reset_req),
    .bit_tick      (bit_tick),
    .bus_recessive (bus_recessive),
    .arb_lost      (arb_lost),
    .bus_off       (bus_off),
    .mode_reset    (mode_reset),
    .mode_sleep    (mode_sleep),
    .mode_ifsleep  (mode_ifsleep),
    .bus_active    (bus_active),
    .trm_state     (trm_state),
    .rec_state     (rec_state),
    .core_clk_en   (core_clk_en),
    .cpu_if_clk_en (cpu_if_clk_en)
);

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;
    localparam int IDLE_BITS = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_req = 1'b1, sleep_req = 1'b0, ifsleep_req = 1'b0, loopback = 1'b0;
    logic bit_tick = 1'b0, bus_recessive = 1'b1;
    logic sof_det = 1'b0, tx_start = 1'b0, arb_lost = 1'b0, frame_done = 1'b0, bus_off = 1'b0;
    logic mode_reset, mode_sleep, mode_ifsleep, bus_active;
    logic trm_state, rec_state, loop_rx, core_clk_en, cpu_if_clk_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    can_mode_seq #(.IDLE_BITS(IDLE_BITS)) dut (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .sleep_req(sleep_req),
        .ifsleep_req(ifsleep_req), .loopback(loopback), .bit_tick(bit_tick),
        .bus_recessive(bus_recessive), .sof_det(sof_det), .tx_start(tx_start),
        .arb_lost(arb_lost), .frame_done(frame_done), .bus_off(bus_off),
        .mode_reset(mode_reset), .mode_sleep(mode_sleep), .mode_ifsleep(mode_ifsleep),
        .bus_active(bus_active), .trm_state(trm_state), .rec_state(rec_state),
        .loop_rx(loop_rx), .core_clk_en(core_clk_en), .cpu_if_clk_en(cpu_if_clk_en)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // packed view: {reset,sleep,ifsleep,active,trm,rec,lrx,core_en,cpu_en}
    function automatic logic [31:0] obs();
        return {23'd0, mode_reset, mode_sleep, mode_ifsleep, bus_active,
                trm_state, rec_state, loop_rx, core_clk_en, cpu_if_clk_en};
    endfunction

    task automatic send_bit(input logic rec);
        bit_tick = 1'b1; bus_recessive = rec;
        cyc(1);
        bit_tick = 1'b0; bus_recessive = 1'b1;
        cyc(1);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        cyc(1);
        sig = 1'b0;
    endtask

    initial begin
        cyc(3);
        chk("R1 in reset", obs(), 32'b100000011);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 after release", obs(), 32'b100000011);

        // enter operation
        reset_req = 1'b0;
        cyc(1);
        chk("R2 operation", obs(), 32'b000000011);

        // R7: events ignored before bus-active
        pulse(sof_det);
        chk("R7 ignored while inactive", {trm_state, rec_state}, 2'b00);

        // R3 sweep: runs of k recessive bits broken by a dominant bit
        for (int k = 1; k < IDLE_BITS; k++) begin
            for (int b = 0; b < k; b++) send_bit(1'b1);
            chk($sformatf("R3 run %0d below limit", k), bus_active, 1'b0);
            send_bit(1'b0);
        end
        for (int b = 0; b < IDLE_BITS - 1; b++) send_bit(1'b1);
        chk("R3 one bit short", bus_active, 1'b0);
        bus_recessive = 1'b1; bit_tick = 1'b1;
        cyc(1);
        bit_tick = 1'b0;
        chk("R3 active after full run", bus_active, 1'b1);

        // R7 sub-mode transitions
        chk("R7 idle 00", {trm_state, rec_state}, 2'b00);
        pulse(sof_det);
        chk("R7 sof to rx 01", {trm_state, rec_state}, 2'b01);
        pulse(frame_done);
        chk("R7 rx done idle", {trm_state, rec_state}, 2'b00);
        sof_det = 1'b1; tx_start = 1'b1;
        cyc(1);
        sof_det = 1'b0; tx_start = 1'b0;
        chk("R7 tx start wins 10", {trm_state, rec_state}, 2'b10);
        chk("R9 no loopback", loop_rx, 1'b0);
        pulse(frame_done);
        chk("R7 tx done idle", {trm_state, rec_state}, 2'b00);

        // R9 loopback, R8 arbitration loss
        loopback = 1'b1;
        pulse(tx_start);
        chk("R9 loopback tx", {trm_state, rec_state, loop_rx}, 3'b101);
        arb_lost = 1'b1; frame_done = 1'b1;
        cyc(1);
        arb_lost = 1'b0; frame_done = 1'b0;
        chk("R8 arb lost to rx", {trm_state, rec_state, loop_rx}, 3'b010);
        pulse(frame_done);
        loopback = 1'b0;

        // R4 sleep ignored in operation
        sleep_req = 1'b1;
        cyc(2);
        chk("R4 sleep ignored in op", obs(), 32'b000100011);
        sleep_req = 1'b0;

        // R10 bus-off
        pulse(tx_start);
        pulse(bus_off);
        chk("R10 bus off", obs(), 32'b100000011);

        // R10 reset request before run completes
        cyc(1); // reset_req=0 -> back in operation
        chk("R2 re-enter op", mode_reset, 1'b0);
        for (int b = 0; b < 5; b++) send_bit(1'b1);
        reset_req = 1'b1;
        cyc(1);
        chk("R10 reset mid-run", {mode_reset, bus_active}, 2'b10);
        reset_req = 1'b0;
        cyc(1);
        for (int b = 0; b < IDLE_BITS - 1; b++) send_bit(1'b1);
        chk("R10 count restarted", bus_active, 1'b0);
        reset_req = 1'b1;
        cyc(1);

        // R6 ifsleep ignored in reset
        ifsleep_req = 1'b1;
        cyc(2);
        chk("R6 ifsleep ignored in reset", obs(), 32'b100000011);
        ifsleep_req = 1'b0;

        // R4/R5 sleep entry
        sleep_req = 1'b1; reset_req = 1'b0;
        cyc(1);
        chk("R4 R5 sleep entry", obs(), 32'b010000001);
        ifsleep_req = 1'b1;
        cyc(1);
        chk("R6 ifsleep entry", obs(), 32'b001000000);

        // R11 wake step by step
        ifsleep_req = 1'b0;
        cyc(1);
        chk("R11 back to sleep", obs(), 32'b010000001);
        reset_req = 1'b1; sleep_req = 1'b0;
        cyc(1);
        chk("R11 back to reset", obs(), 32'b100000011);

        // R11 clearing both requests still passes through sleep
        reset_req = 1'b0; sleep_req = 1'b1;
        cyc(1);
        ifsleep_req = 1'b1;
        cyc(1);
        chk("R6 ifsleep again", mode_ifsleep, 1'b1);
        reset_req = 1'b1; sleep_req = 1'b0; ifsleep_req = 1'b0;
        cyc(1);
        chk("R11 step via sleep", obs(), 32'b010000001);
        cyc(1);
        chk("R11 then reset", obs(), 32'b100000011);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule